// File: doc/BRIEF.md
# Clock, Reset and Ready Generator

This block turns one fast source clock into the two clocks a small processor system runs on. It also makes the reset and wait-state handshake that goes with those clocks. The source is either a crystal-derived clock or an external frequency input, chosen by a select pin, and it is passed straight out for other boards. The processor clock runs at one third of the source and is high for one source period in three. The peripheral clock runs at half the processor clock, with an even duty cycle. A hold input stops both dividers at a known phase, so that several generators fed from one external frequency can be started in step.

A board-level active-low reset request asserts the processor reset at once, without waiting for any clock. The reset is released in step with the processor clock. Two ready requests, each qualified by its own active-low enable, are merged into one ready line. That line is registered twice on the processor clock, so a slave that is not ready stretches the bus cycle by wait states.

Top module: `clk_rst_rdy_gen`

## Requirements
- R1: `cpu_clk` repeats every 3 source rising edges and is high for exactly 1 of them. Counting the source edges after `sync_hold` falls as 1, 2, 3, ..., it is high after edges 3, 6, 9, ... and low otherwise.
- R2: `per_clk` repeats every 6 source rising edges and is high for 3 of them. It changes only at the source edge where `cpu_clk` rises, and it is high after edges 3 to 5 of each 6-edge group, using the same count as R1.
- R3: `src_sel` = 1 selects `efi_clk` as the source and `src_sel` = 0 selects `xtal_clk`; `osc_out` always equals the selected source.
- R4: While `sync_hold` is sampled high on a source rising edge, `cpu_clk` is held high and `per_clk` low. Counting resumes on the first source rising edge at which `sync_hold` is sampled low, and after that edge `cpu_clk` is low.
- R5: While `res_n` is low, `cpu_reset` is high, and it rises as soon as `res_n` falls, with no clock edge needed.
- R6: After `res_n` rises, `cpu_reset` falls on the second falling edge of `cpu_clk`.
- R7: The merged ready value is `(rdy_a AND NOT aen_a_n) OR (rdy_b AND NOT aen_b_n)`.
- R8: `cpu_ready` shows the merged ready value sampled at the rising edge of `cpu_clk` two rising edges earlier. It is low while `res_n` is low and for the first two rising edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal-derived source clock |
| efi_clk | input | 1 | External frequency source clock |
| src_sel | input | 1 | Source select: 1 = external, 0 = crystal |
| sync_hold | input | 1 | Holds the dividers at phase 0 while high |
| res_n | input | 1 | Active-low asynchronous reset request |
| rdy_a | input | 1 | Ready request of slave group A |
| aen_a_n | input | 1 | Active-low enable qualifying rdy_a |
| rdy_b | input | 1 | Ready request of slave group B |
| aen_b_n | input | 1 | Active-low enable qualifying rdy_b |
| osc_out | output | 1 | Copy of the selected source clock |
| cpu_clk | output | 1 | Source divided by 3, high one period in three |
| per_clk | output | 1 | Processor clock divided by 2, even duty |
| cpu_reset | output | 1 | Active-high processor reset |
| cpu_ready | output | 1 | Twice-registered merged ready |

## Verification
On every source edge the assertions check the local shape of the clocks: a high `cpu_clk` phase lasts one edge, a low phase lasts two, `per_clk` moves only where `cpu_clk` rises, and the hold forces the phase-0 pattern. On every edge they also check that reset is immediate while the request is low, that release lands while `cpu_clk` is low, and that the ready pipeline is exactly two processor edges deep. Only the bench scenarios show the absolute phase alignment after a hold release, and correct behaviour across a source switch. They also show a reset pulse in mid-run and that every one of the sixteen enable/request combinations merges correctly.

// File: rtl/ckgen_pkg.sv
package ckgen_pkg;
  // Merge of two ready requests, each qualified by an active-low enable.
  function automatic logic ready_merge(input logic ra, input logic ea_n,
                                       input logic rb, input logic eb_n);
    return (ra & ~ea_n) | (rb & ~eb_n);
  endfunction
endpackage

// File: rtl/ckgen_div.sv
module ckgen_div #(
  parameter int DIV_CPU = 3
) (
  input  logic src_clk,
  input  logic hold,
  output logic cpu_clk,
  output logic per_clk,
  output logic cpu_wrap
);
  localparam logic [DIV_CPU-1:0] PHASE0 = DIV_CPU'(1);

  logic [DIV_CPU-1:0] ring_q;
  logic               per_q;

  // One-hot phase ring: bit 0 drives the processor clock directly.
  assign cpu_wrap = ring_q[DIV_CPU-1] & ~hold;

  always_ff @(posedge src_clk) begin
    if (hold) ring_q <= PHASE0;
    else      ring_q <= {ring_q[DIV_CPU-2:0], ring_q[DIV_CPU-1]};
  end

  always_ff @(posedge src_clk) begin
    if (hold)          per_q <= 1'b0;
    else if (cpu_wrap) per_q <= ~per_q;
  end

  assign cpu_clk = ring_q[0];
  assign per_clk = per_q;
endmodule

// File: rtl/ckgen_rst_sync.sv
module ckgen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_out
);
  logic [STAGES-1:0] sh_q;

  // Asserts asynchronously, releases on falling clock edges.
  always_ff @(negedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_out = ~sh_q[STAGES-1];
endmodule

// File: rtl/ckgen_rdy_sync.sv
module ckgen_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/clk_rst_rdy_gen.sv
module clk_rst_rdy_gen #(
  parameter int DIV_CPU    = 3,
  parameter int RST_STAGES = 2,
  parameter int RDY_STAGES = 2
) (
  input  logic xtal_clk,
  input  logic efi_clk,
  input  logic src_sel,
  input  logic sync_hold,
  input  logic res_n,
  input  logic rdy_a,
  input  logic aen_a_n,
  input  logic rdy_b,
  input  logic aen_b_n,
  output logic osc_out,
  output logic cpu_clk,
  output logic per_clk,
  output logic cpu_reset,
  output logic cpu_ready
);
  import ckgen_pkg::*;

  logic src_clk;
  logic cpu_wrap;
  logic ready_raw;

  assign src_clk   = src_sel ? efi_clk : xtal_clk;
  assign osc_out   = src_clk;
  assign ready_raw = ready_merge(rdy_a, aen_a_n, rdy_b, aen_b_n);

  ckgen_div #(.DIV_CPU(DIV_CPU)) u_div (
    .src_clk (src_clk),
    .hold    (sync_hold),
    .cpu_clk (cpu_clk),
    .per_clk (per_clk),
    .cpu_wrap(cpu_wrap)
  );

  ckgen_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (cpu_clk),
    .arst_n (res_n),
    .rst_out(cpu_reset)
  );

  ckgen_rdy_sync #(.STAGES(RDY_STAGES)) u_rdy (
    .clk   (cpu_clk),
    .arst_n(res_n),
    .d     (ready_raw),
    .q     (cpu_ready)
  );
endmodule

// File: rtl/ckgen_chk.sv
module ckgen_chk (
  input logic osc_out,
  input logic sync_hold,
  input logic res_n,
  input logic rdy_a,
  input logic aen_a_n,
  input logic rdy_b,
  input logic aen_b_n,
  input logic cpu_clk,
  input logic per_clk,
  input logic cpu_reset,
  input logic cpu_ready,
  input logic cpu_wrap
);
  import ckgen_pkg::*;

  logic       merge_in;
  logic [1:0] rel_cnt;

  assign merge_in = ready_merge(rdy_a, aen_a_n, rdy_b, aen_b_n);

  always_ff @(posedge cpu_clk or negedge res_n) begin
    if (!res_n)              rel_cnt <= 2'd0;
    else if (rel_cnt != 2'd2) rel_cnt <= rel_cnt + 2'd1;
  end

  // R1: a high phase lasts one source edge
  a_r1_high_one_edge: assert property (@(posedge osc_out) disable iff (sync_hold || !res_n)
    cpu_clk |=> !cpu_clk);
  // R1: a low phase lasts two source edges
  a_r1_low_two_edges: assert property (@(posedge osc_out) disable iff (sync_hold || !res_n)
    (!cpu_clk && !$past(cpu_clk)) |=> cpu_clk);
  // R2: peripheral clock moves only where the processor clock rises
  a_r2_per_moves_at_rise: assert property (@(posedge osc_out) disable iff (sync_hold || !res_n)
    !$stable(per_clk) |-> $rose(cpu_clk));
  // R2: a divider wrap precedes a processor clock rise
  a_r2_wrap_then_rise: assert property (@(posedge osc_out) disable iff (sync_hold || !res_n)
    cpu_wrap |=> cpu_clk);
  // R4: hold forces phase 0
  a_r4_hold_phase0: assert property (@(posedge osc_out) disable iff (!res_n)
    sync_hold |=> (cpu_clk && !per_clk));
  // R6: release lands while the processor clock is low
  a_r6_release_on_fall: assert property (@(posedge osc_out) disable iff (!res_n)
    $fell(cpu_reset) |-> !cpu_clk);
  // R7, R8: ready pipeline is two processor edges deep
  a_r8_ready_depth: assert property (@(posedge cpu_clk) disable iff (!res_n)
    (rel_cnt == 2'd2) |-> (cpu_ready == $past(merge_in, 2)));

  always @(posedge osc_out) begin
    if (!res_n) begin
      a_r5_reset_while_low: assert (cpu_reset) else $error("R5 reset not held");
      a_r8_ready_low_in_reset: assert (!cpu_ready) else $error("R8 ready not low");
    end
  end
endmodule

bind clk_rst_rdy_gen ckgen_chk u_chk (
  .osc_out  (osc_out),
  .sync_hold(sync_hold),
  .res_n    (res_n),
  .rdy_a    (rdy_a),
  .aen_a_n  (aen_a_n),
  .rdy_b    (rdy_b),
  .aen_b_n  (aen_b_n),
  .cpu_clk  (cpu_clk),
  .per_clk  (per_clk),
  .cpu_reset(cpu_reset),
  .cpu_ready(cpu_ready),
  .cpu_wrap (cpu_wrap)
);

// File: tb/tb_clk_rst_rdy_gen.sv
module tb_clk_rst_rdy_gen;
  logic xtal_clk = 1'b0;
  logic efi_clk  = 1'b0;
  logic src_sel  = 1'b0;
  logic sync_hold = 1'b1;
  logic res_n    = 1'b1;
  logic rdy_a = 1'b0, aen_a_n = 1'b1, rdy_b = 1'b0, aen_b_n = 1'b1;
  logic osc_out, cpu_clk, per_clk, cpu_reset, cpu_ready;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 xtal_clk = ~xtal_clk;  // 50 MHz
  always #7  efi_clk  = ~efi_clk;

  logic src_m;
  assign src_m = src_sel ? efi_clk : xtal_clk;

  clk_rst_rdy_gen dut (
    .xtal_clk(xtal_clk), .efi_clk(efi_clk), .src_sel(src_sel),
    .sync_hold(sync_hold), .res_n(res_n),
    .rdy_a(rdy_a), .aen_a_n(aen_a_n), .rdy_b(rdy_b), .aen_b_n(aen_b_n),
    .osc_out(osc_out), .cpu_clk(cpu_clk), .per_clk(per_clk),
    .cpu_reset(cpu_reset), .cpu_ready(cpu_ready)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: position in a 6-edge group, edge counters, two slots.
  int   pos = 0;
  bit   valid = 1'b0;
  bit   clk_m = 1'b0;
  int   falls = 0;
  logic slot1 = 1'b0, slot2 = 1'b0;

  function automatic logic bench_merge(input logic ra, input logic ea_n,
                                       input logic rb, input logic eb_n);
    if (ra === 1'b1 && ea_n === 1'b0) return 1'b1;
    if (rb === 1'b1 && eb_n === 1'b0) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge src_m) begin
    bit nclk;
    if (sync_hold) begin pos = 0; valid = 1'b1; end
    else pos = (pos + 1) % 6;
    nclk = (pos == 0 || pos == 3);
    if (!res_n) begin
      falls = 0; slot1 = 1'b0; slot2 = 1'b0;
    end else begin
      if (clk_m && !nclk && falls < 2) falls++;
      if (!clk_m && nclk) begin
        slot2 = slot1;
        slot1 = bench_merge(rdy_a, aen_a_n, rdy_b, aen_b_n);
      end
    end
    clk_m = nclk;
  end

  always @(posedge src_m) begin
    #1;
    if (valid) chk("R3 osc", osc_out, src_m);
  end

  always @(negedge src_m) begin
    if (valid && !finished) begin
      chk(sync_hold ? "R4 cpu_clk" : "R1 cpu_clk", cpu_clk, (pos == 0 || pos == 3));
      chk(sync_hold ? "R4 per_clk" : "R2 per_clk", per_clk, (pos >= 3));
      chk(!res_n ? "R5 reset" : "R6 reset", cpu_reset, (!res_n || falls < 2));
      chk("R8 ready", cpu_ready, res_n ? slot2 : 1'b0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge src_m);
    #2;
  endtask

  initial begin : watchdog
    #(200000 * 20);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] lfsr;
    #5 res_n = 1'b0;
    step(4);
    chk("R5 reset at start", cpu_reset, 1'b1);
    sync_hold = 1'b0;
    step(5);
    res_n = 1'b1;
    step(12);
    chk("R6 released", cpu_reset, 1'b0);
    // R7: every request/enable combination
    for (int i = 0; i < 16; i++) begin
      {rdy_a, aen_a_n, rdy_b, aen_b_n} = 4'(i);
      step(9);
      chk("R7 merge", cpu_ready, (i[3] && !i[2]) || (i[1] && !i[0]));
    end
    // R8: ready inputs changing every source edge
    lfsr = 8'hA5;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      {rdy_a, aen_a_n, rdy_b, aen_b_n} = lfsr[3:0];
      step(1);
    end
    // R4: hold in mid-phase, then resume
    step(4);
    sync_hold = 1'b1;
    step(3);
    chk("R4 held high", cpu_clk, 1'b1);
    sync_hold = 1'b0;
    step(20);
    // R5, R6: reset pulse in mid-run
    res_n = 1'b0;
    #1 chk("R5 immediate", cpu_reset, 1'b1);
    step(3);
    res_n = 1'b1;
    step(12);
    // R3: switch to the external source under hold
    sync_hold = 1'b1;
    step(2);
    src_sel = 1'b1;
    step(3);
    sync_hold = 1'b0;
    for (int i = 0; i < 120; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      {rdy_a, aen_a_n, rdy_b, aen_b_n} = lfsr[7:4];
      step(1);
    end
    step(4);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule